// File: doc/BRIEF.md
# Wrap-Extended Timestamp Counter

This block widens a free-running binary counter of modest width into a wide, monotonic timestamp. Each time it takes a sample of the counter, it compares that sample with the sample it took before. A smaller value than last time can only mean that the counter rolled over, so a high word kept inside the block is advanced by one. The timestamp it returns is the high word placed above the sample. The sample used for the compare and the sample placed in the result are the same value.

Samples are taken on two occasions. The first is a read request, which arrives on a valid/ready input channel; its result leaves on a valid/ready output channel. The second is a periodic tick, which updates the state silently and gives no result. The tick keeps rollovers from being missed when reads are rare. A tick and a read in the same cycle form one check. A valid flag, cleared by reset, keeps the very first sample from being mistaken for a rollover. While the counter is reported as not running, reads return zero and no state changes. The block counts at most one rollover between two samples.

Back-pressure rules: a result stays on the output with unchanged data until it is taken (`ts_valid` and `ts_ready` both high). While a result waits, `req_ready` is low, and a request that is not accepted has no effect on the block. `req_ready` is high whenever the output holds nothing or is being drained in that cycle.

Top module: `wrapext_timestamp`

## Requirements
- R1: After reset the output channel is empty (`ts_valid` low), `req_ready` is high, and the high word is zero.
- R2: A check counts a rollover, and adds one to the high word, only when the previous sample is strictly greater than the current one; an equal or larger sample leaves the high word unchanged.
- R3: The first check after reset never counts a rollover, whatever value the counter held before reset.
- R4: Every check records its sample as the previous value for the next check.
- R5: An accepted request gives `ts_valid` high on the next cycle, with `ts_data` equal to the high word after the check in the upper bits and the sampled counter value in the low `LOW_W` bits.
- R6: While `cnt_running` is low, an accepted request returns zero, and neither reads nor ticks change the high word or the previous sample.
- R7: A tick with no request runs the check and updates state but puts no result on the output.
- R8: A tick and an accepted request in the same cycle make a single check; the high word advances by at most one in any cycle.
- R9: While `ts_valid` is high and `ts_ready` is low, `ts_valid` stays high, `ts_data` holds, `req_ready` is low, and a pending request leaves the state untouched.
- R10: Across a sequence of rollovers, including a sample of zero straight after the all-ones value, returned timestamps never decrease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_running | input | 1 | High once the free-running counter has been started |
| cnt_value | input | LOW_W | Current value of the free-running counter |
| tick | input | 1 | Periodic check event, one cycle per event |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Read request can be taken this cycle |
| ts_valid | output | 1 | Timestamp result available |
| ts_ready | input | 1 | Consumer takes the result |
| ts_data | output | HIGH_W+LOW_W | Composed timestamp |

## Verification
State changes land at the clock edge where a tick or an accepted request is seen, and the matching result is visible on `ts_valid`/`ts_data` one cycle later. The bench drives every stimulus half a period before that edge and reads the output half a period after it, so each read is checked exactly one cycle after it was accepted. Tick-only steps have no output, so their effect is checked through the result of the next read. Under back-pressure the bench samples the held result on every stalled cycle and checks the first read after release against the state from before the stall.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic [1:0] {
    CX_IDLE = 2'b00,
    CX_TICK = 2'b01,
    CX_READ = 2'b10,
    CX_BOTH = 2'b11
  } cx_cause_e;

  function automatic cx_cause_e cx_cause(input logic tick_ev, input logic read_ev);
    return cx_cause_e'({read_ev, tick_ev});
  endfunction
endpackage

// File: rtl/cx_wrap_detect.sv
module cx_wrap_detect #(
  parameter int LOW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_i,
  input  logic [LOW_W-1:0] sample_i,
  output logic             wrap_o
);
  logic [LOW_W-1:0] prev_q;
  logic             seen_q;

  // prev_q carries no reset: seen_q gates it until the first check
  always_ff @(posedge clk) begin
    if (chk_i) prev_q <= sample_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     seen_q <= 1'b0;
    else if (chk_i) seen_q <= 1'b1;
  end

  always_comb wrap_o = chk_i && seen_q && (prev_q > sample_i);
endmodule

// File: rtl/cx_high_word.sv
module cx_high_word #(
  parameter int HIGH_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_i,
  input  logic              wrap_i,
  output logic [HIGH_W-1:0] high_next_o
);
  logic [HIGH_W-1:0] high_q;

  always_comb high_next_o = high_q + HIGH_W'(wrap_i);

  always_ff @(posedge clk) begin
    if (!rst_n)     high_q <= '0;
    else if (chk_i) high_q <= high_next_o;
  end

  AST_HIGH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (high_q == $past(high_q)) || (high_q == HIGH_W'($past(high_q) + 1'b1))); // R8
  AST_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_i |=> $stable(high_q)); // R7
endmodule

// File: rtl/cx_ts_out.sv
module cx_ts_out #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            zero_i,
  input  logic [TS_W-1:0] data_i,
  input  logic            ts_ready_i,
  output logic            ts_valid_o,
  output logic [TS_W-1:0] ts_data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_valid_o <= 1'b0;
      ts_data_o  <= '0;
    end else if (load_i) begin
      ts_valid_o <= 1'b1;
      ts_data_o  <= zero_i ? '0 : data_i;
    end else if (ts_ready_i) begin
      ts_valid_o <= 1'b0;
    end
  end

  AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid_o && !ts_ready_i) |=> (ts_valid_o && $stable(ts_data_o))); // R9
endmodule

// File: rtl/wrapext_timestamp.sv
module wrapext_timestamp #(
  parameter int LOW_W  = 32,
  parameter int HIGH_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cnt_running,
  input  logic [LOW_W-1:0]        cnt_value,
  input  logic                    tick,
  input  logic                    req_valid,
  output logic                    req_ready,
  output logic                    ts_valid,
  input  logic                    ts_ready,
  output logic [HIGH_W+LOW_W-1:0] ts_data
);
  import cx_pkg::*;

  localparam int TS_W = HIGH_W + LOW_W;

  logic              fire;
  logic              chk;
  logic              wrap;
  logic [HIGH_W-1:0] high_next;
  cx_cause_e         cause;

  always_comb begin
    req_ready = !ts_valid || ts_ready;
    fire      = req_valid && req_ready;
    cause     = cnt_running ? cx_cause(tick, fire) : CX_IDLE;
    chk       = (cause != CX_IDLE);
  end

  cx_wrap_detect #(.LOW_W(LOW_W)) wrap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_i    (chk),
    .sample_i (cnt_value),
    .wrap_o   (wrap)
  );

  cx_high_word #(.HIGH_W(HIGH_W)) high_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_i       (chk),
    .wrap_i      (wrap),
    .high_next_o (high_next)
  );

  cx_ts_out #(.TS_W(TS_W)) out_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (fire),
    .zero_i     (!cnt_running),
    .data_i     ({high_next, cnt_value}),
    .ts_ready_i (ts_ready),
    .ts_valid_o (ts_valid),
    .ts_data_o  (ts_data)
  );

  AST_REQ_TO_TS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ts_valid); // R5
  AST_ZERO_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cnt_running) |=> (ts_data == '0)); // R6
endmodule

// File: tb/wrapext_timestamp_tb_top.sv
module wrapext_timestamp_tb_top;
  localparam int SL = 4;
  localparam int SH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // small configuration
  logic          s_run = 1'b0, s_tick = 1'b0, s_rv = 1'b0, s_tr = 1'b1;
  logic [SL-1:0] s_cnt = '0;
  logic          s_rr, s_tv;
  logic [SH+SL-1:0] s_ts;

  // full-width configuration
  logic        w_run = 1'b0, w_rv = 1'b0;
  logic [31:0] w_cnt = '0;
  logic        w_rr, w_tv;
  logic [63:0] w_ts;

  wrapext_timestamp #(.LOW_W(SL), .HIGH_W(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_running(s_run), .cnt_value(s_cnt),
    .tick(s_tick), .req_valid(s_rv), .req_ready(s_rr),
    .ts_valid(s_tv), .ts_ready(s_tr), .ts_data(s_ts)
  );

  wrapext_timestamp dut_w (
    .clk(clk), .rst_n(rst_n), .cnt_running(w_run), .cnt_value(w_cnt),
    .tick(1'b0), .req_valid(w_rv), .req_ready(w_rr),
    .ts_valid(w_tv), .ts_ready(1'b1), .ts_data(w_ts)
  );

  // reference model of the small configuration
  int m_prev = 0;
  bit m_seen = 0;
  int m_high = 0;
  longint last_ts = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic s_step(input int cnt, input bit rd, input bit tk, input string req);
    longint exp;
    bit wr;
    @(negedge clk);
    s_cnt = SL'(cnt); s_rv = rd; s_tick = tk;
    wr = m_seen && (m_prev > cnt);
    exp = s_run ? longint'(((m_high + int'(wr)) % 256) * 16 + cnt) : 0;
    if (s_run && (rd || tk)) begin
      m_high = (m_high + int'(wr)) % 256;
      m_prev = cnt;
      m_seen = 1;
    end
    @(negedge clk);
    s_rv = 1'b0; s_tick = 1'b0;
    if (rd) begin
      check(s_tv == 1'b1, {req, " valid"}, longint'(s_tv), 1);
      check(longint'(s_ts) == exp, req, longint'(s_ts), exp);
      if (s_run) begin
        check(longint'(s_ts) >= last_ts, "R10 monotonic", longint'(s_ts), last_ts);
        last_ts = longint'(s_ts);
      end
    end
  endtask

  task automatic w_read(input logic [31:0] cnt, input logic [63:0] exp, input string req);
    @(negedge clk);
    w_cnt = cnt; w_rv = 1'b1;
    @(negedge clk);
    w_rv = 1'b0;
    check(w_tv == 1'b1, {req, " valid"}, longint'(w_tv), 1);
    check(w_ts == exp, req, longint'(w_ts), longint'(exp));
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [SH+SL-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(s_tv == 1'b0, "R1 ts_valid", longint'(s_tv), 0);
    check(s_rr == 1'b1, "R1 req_ready", longint'(s_rr), 1);

    // R6 not running: zero result, no state change
    s_step(9, 1, 0, "R6 read while stopped");
    s_step(2, 0, 1, "R6 tick while stopped");
    s_run = 1'b1;
    // R3 first sample never wraps; R1 high starts at zero
    s_step(3, 1, 0, "R3 first sample");
    s_step(3, 1, 0, "R2 equal no wrap");
    s_step(2, 1, 0, "R2 decrease wraps");

    // sweep: reads, tick-only steps (R7), merged tick+read (R8), R4 chain
    for (int i = 0; i < 256; i++) begin
      int v;
      v = (i * 5 + (i / 16) * 3) % 16;
      case (i % 3)
        0: s_step(v, 1, 0, "R5 read sweep");
        1: s_step(v, 0, 1, "R7 tick only");
        default: s_step(v, 1, 1, "R8 merged tick and read");
      endcase
    end

    // R6 stopped again: state kept across stop, prev still remembered (R4)
    s_step(15, 1, 0, "R4 set prev high");
    s_run = 1'b0;
    s_step(1, 1, 1, "R6 stopped read");
    s_run = 1'b1;
    s_step(8, 1, 0, "R6 prev kept across stop");

    // R9 back-pressure
    @(negedge clk);
    s_tr = 1'b0; s_rv = 1'b1; s_cnt = 4'd10;
    if (m_prev > 10) m_high = (m_high + 1) % 256;
    m_prev = 10;
    @(negedge clk);
    held = s_ts;
    check(s_tv == 1'b1, "R9 result pending", longint'(s_tv), 1);
    check(longint'(s_ts) == longint'(m_high * 16 + 10), "R9 pending data", longint'(s_ts), longint'(m_high * 16 + 10));
    s_cnt = 4'd1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(s_rr == 1'b0, "R9 req_ready low", longint'(s_rr), 0);
      check(s_tv == 1'b1 && s_ts == held, "R9 data held", longint'(s_ts), longint'(held));
    end
    s_rv = 1'b0; s_tr = 1'b1;
    @(negedge clk);
    check(s_tv == 1'b0, "R9 drained", longint'(s_tv), 0);
    s_step(12, 1, 0, "R9 stalled request had no effect");

    // R3 reset mid-run with large prev: first sample again no wrap
    s_step(15, 1, 0, "R4 prev before reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_seen = 0; m_high = 0; last_ts = 0;
    check(s_tv == 1'b0, "R1 ts_valid after reset", longint'(s_tv), 0);
    s_step(3, 1, 0, "R3 first sample after reset");
    w_run = 1'b0;

    // full width: R10 all-ones then zero
    w_read(32'h0000_0005, 64'h0, "R6 wide stopped");
    w_run = 1'b1;
    w_read(32'hFFFF_FFFE, 64'h0000_0000_FFFF_FFFE, "R3 wide first");
    w_read(32'hFFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "R10 wide all ones");
    w_read(32'h0000_0000, 64'h0000_0001_0000_0000, "R10 wide zero after all ones");
    w_read(32'h0000_0000, 64'h0000_0001_0000_0000, "R2 wide equal");
    w_read(32'h0000_0007, 64'h0000_0001_0000_0007, "R5 wide rise");
    w_read(32'h0000_0003, 64'h0000_0002_0000_0003, "R10 wide second wrap");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule